// File: doc/BRIEF.md
# Stack Push/Pop Execution Unit

This unit carries out one single-register stack instruction at a time, either a push or a pop, for a processor that runs 16-, 32- and 64-bit code. A start strobe supplies the code mode, an operand-size override flag, the direction and a register index. The unit chooses the operand width, moves the stack pointer, and moves the data between the register and memory. When it finishes it raises a one-cycle done pulse and reports the instruction length.

The unit holds a small general register file, and the stack pointer is one of its entries. Other logic can load and observe this register file through a write port and a combinational read port. Memory is reached through a little-endian, word-aligned bus with byte-lane enables. An operand that covers more than one bus word is sent as several beats, and each beat is held until memory signals ready.

A pop whose target is the stack pointer follows a special order. The increment is written first, and the popped value is then written into the operand-sized low part of the incremented pointer. Any upper bits that the increment carried into are therefore kept.

Top module: `stk_pushpop_unit`

## Requirements
- R1: The operand size depends on the mode and the override. Without the override it is 2 bytes in 16-bit mode (mode=0), 4 bytes in 32-bit mode (mode=1) and 8 bytes in 64-bit mode (mode=2 or 3). With the override it is 4, 2 and 2 bytes in those modes.
- R2: While done is high, instr_len reads 1 for an instruction without the override and 2 for one with it.
- R3: A push lowers SP by the operand size. It then stores the low operand-size bytes of the source register little-endian at the new SP. The bytes just below and just above that range do not change.
- R4: A push of SP (register index 4) stores the SP value from before the decrement.
- R5: A 2-byte pop writes bits 15:0 of the target register and keeps bits 63:16.
- R6: A 4-byte pop writes bits 31:0 of the target register and clears bits 63:32. An 8-byte pop replaces all 64 bits.
- R7: A pop into SP first writes SP plus the operand size. It then writes the popped value into the operand-sized low part of that incremented SP, following the rules of R5 and R6.
- R8: In 32-bit and 64-bit modes, SP arithmetic and the stack address use all 64 bits. An access that crosses a 64 KB boundary carries into bit 16 and does not wrap.
- R9: In 16-bit mode, the stack address is SP[15:0] zero-extended. The SP update wraps within bits 15:0, and bits 63:16 of SP stay unchanged.
- R10: Every memory beat has an address that is a multiple of 4 and a nonzero byte-enable mask over 4 lanes (lane j is byte address+j). A beat holds its address, mask and direction until mem_ready is sampled high. An access therefore takes floor((addr mod 4 + size - 1)/4) + 1 beats.
- R11: done is high for exactly one cycle. Count cycles from the clock edge that samples start, and count each cycle of the memory stall in which mem_ready is low. The pulse is seen 2 + beats + stall cycles later for a push, and 3 + beats + stall cycles later for a pop.
- R12: A start while an instruction is in progress is ignored and produces no extra done.
- R13: After reset, done and mem_req are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (sampled only while idle) |
| mode | input | 2 | Code mode: 0 = 16-bit, 1 = 32-bit, 2 or 3 = 64-bit |
| opsz_ovr | input | 1 | Operand-size override present |
| is_pop | input | 1 | 1 = pop, 0 = push |
| reg_idx | input | 4 | Source or target register index (SP is index 4) |
| done | output | 1 | One-cycle completion pulse |
| instr_len | output | 2 | Instruction length in bytes, valid with done |
| rf_wr_en | input | 1 | External register write enable |
| rf_wr_idx | input | 4 | External register write index |
| rf_wr_data | input | 64 | External register write data |
| rf_rd_idx | input | 4 | Observation read index |
| rf_rd_data | output | 64 | Observation read data (combinational) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 64 | Word-aligned beat address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data by lane |
| mem_rdata | input | 32 | Read data by lane, valid with mem_ready |
| mem_ready | input | 1 | Beat accepted at this clock edge |

## Verification
The result of each instruction is due at a known cycle. The register write-back lands with the done pulse, which comes 2 + beats + stall cycles after the sampling edge for a push and one cycle later for a pop. The bench memory model counts the stall cycles it inserts. The scoreboard monitor compares the measured distance from the start edge to done with the expected distance, using the beat count worked out from the stack address. Registers and memory bytes are read at the falling edge of the done cycle, once the final write has landed and before any later instruction can change them.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int XLEN   = 64;
    localparam int XBYTES = XLEN / 8;

    typedef enum logic [1:0] {
        MODE_16  = 2'd0,
        MODE_32  = 2'd1,
        MODE_64  = 2'd2,
        MODE_64B = 2'd3
    } code_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MEM   = 2'd1,
        ST_SPWB  = 2'd2,
        ST_REGWB = 2'd3
    } stk_state_e;

    typedef struct packed {
        logic       is_pop;
        logic       narrow;
        logic [3:0] nbytes;
        logic [1:0] ilen;
    } op_ctx_t;

    // Stack pointer step: a narrow stack moves only the low 16 bits.
    function automatic logic [XLEN-1:0] sp_step(input logic [XLEN-1:0] sp,
                                                input logic [3:0]      n,
                                                input logic            narrow,
                                                input logic            down);
        logic [XLEN-1:0] wide;
        logic [15:0]     low;
        wide = down ? (sp - XLEN'(n)) : (sp + XLEN'(n));
        low  = down ? (sp[15:0] - 16'(n)) : (sp[15:0] + 16'(n));
        return narrow ? {sp[XLEN-1:16], low} : wide;
    endfunction

    // Write-back of a popped value into the current register contents.
    function automatic logic [XLEN-1:0] pop_merge(input logic [XLEN-1:0] cur,
                                                  input logic [XLEN-1:0] val,
                                                  input logic [3:0]      n);
        case (n)
            4'd2:    return {cur[XLEN-1:16], val[15:0]};
            4'd4:    return {{(XLEN-32){1'b0}}, val[31:0]};
            default: return val;
        endcase
    endfunction

endpackage

// File: rtl/stk_opsize.sv
module stk_opsize
    import stk_pkg::*;
(
    input  code_mode_e mode,
    input  logic       ovr,
    output logic [3:0] nbytes,
    output logic [1:0] ilen,
    output logic       narrow
);
    always_comb begin
        unique case (mode)
            MODE_16: nbytes = ovr ? 4'd4 : 4'd2;
            MODE_32: nbytes = ovr ? 4'd2 : 4'd4;
            default: nbytes = ovr ? 4'd2 : 4'd8;
        endcase
        ilen   = ovr ? 2'd2 : 2'd1;
        narrow = (mode == MODE_16);
    end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile
    import stk_pkg::*;
#(
    parameter int NREGS  = 16,
    parameter int SP_IDX = 4,
    parameter int IDXW   = $clog2(NREGS)
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            int_we,
    input  logic [IDXW-1:0] int_idx,
    input  logic [XLEN-1:0] int_data,
    input  logic            ext_we,
    input  logic [IDXW-1:0] ext_idx,
    input  logic [XLEN-1:0] ext_data,
    input  logic [IDXW-1:0] src_idx,
    output logic [XLEN-1:0] src_data,
    input  logic [IDXW-1:0] obs_idx,
    output logic [XLEN-1:0] obs_data,
    output logic [XLEN-1:0] sp_data
);
    logic [XLEN-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else begin
            if (ext_we) regs_q[ext_idx] <= ext_data;
            if (int_we) regs_q[int_idx] <= int_data;   // internal write wins
        end
    end

    assign src_data = regs_q[src_idx];
    assign obs_data = regs_q[obs_idx];
    assign sp_data  = regs_q[SP_IDX];
endmodule

// File: rtl/stk_mem_seq.sv
module stk_mem_seq
    import stk_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LW    = $clog2(LANES),
    parameter int MAXB  = (XBYTES + LANES - 2) / LANES + 1,
    parameter int BCW   = $clog2(MAXB + 1)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic               go_we,
    input  logic [XLEN-1:0]    go_addr,
    input  logic [3:0]         go_n,
    input  logic [XLEN-1:0]    go_data,
    output logic               fin,
    output logic [XLEN-1:0]    rd_acc,
    output logic               mem_req,
    output logic               mem_we,
    output logic [XLEN-1:0]    mem_addr,
    output logic [LANES-1:0]   mem_be,
    output logic [LANES*8-1:0] mem_wdata,
    input  logic [LANES*8-1:0] mem_rdata,
    input  logic               mem_ready
);
    localparam int BIW = $clog2(XBYTES);

    logic            busy_q, we_q;
    logic [XLEN-1:0] base_q, data_q, acc_q;
    logic [LW-1:0]   align_q;
    logic [3:0]      n_q;
    logic [BCW-1:0]  beat_q, last_q, go_last;
    logic [LANES-1:0] hit;
    logic [BIW-1:0]  bidx [LANES];

    always_comb begin
        int t;
        t       = int'(go_addr[LW-1:0]) + int'(go_n) - 1;
        go_last = BCW'(t / LANES);
    end

    // Which operand byte each lane carries in the current beat.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            int pos;
            pos     = int'(beat_q) * LANES + j - int'(align_q);
            hit[j]  = (pos >= 0) && (pos < int'(n_q));
            bidx[j] = BIW'(pos);
        end
    end

    always_comb begin
        mem_be    = '0;
        mem_wdata = '0;
        for (int j = 0; j < LANES; j++) begin
            if (hit[j]) begin
                mem_be[j]          = 1'b1;
                mem_wdata[j*8 +: 8] = data_q[8*bidx[j] +: 8];
            end
        end
    end

    assign mem_req  = busy_q;
    assign mem_we   = we_q;
    assign mem_addr = base_q + (XLEN'(beat_q) << LW);
    assign fin      = busy_q && mem_ready && (beat_q == last_q);
    assign rd_acc   = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            we_q    <= 1'b0;
            base_q  <= '0;
            data_q  <= '0;
            acc_q   <= '0;
            align_q <= '0;
            n_q     <= '0;
            beat_q  <= '0;
            last_q  <= '0;
        end else if (!busy_q) begin
            if (go) begin
                busy_q  <= 1'b1;
                we_q    <= go_we;
                base_q  <= {go_addr[XLEN-1:LW], {LW{1'b0}}};
                align_q <= go_addr[LW-1:0];
                n_q     <= go_n;
                data_q  <= go_data;
                acc_q   <= '0;
                beat_q  <= '0;
                last_q  <= go_last;
            end
        end else if (mem_ready) begin
            if (!we_q) begin
                for (int j = 0; j < LANES; j++) begin
                    if (hit[j]) acc_q[8*bidx[j] +: 8] <= mem_rdata[j*8 +: 8];
                end
            end
            if (beat_q == last_q) busy_q <= 1'b0;
            else                  beat_q <= beat_q + 1'b1;
        end
    end

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we))) // R10
        else $error("beat changed before ready");
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[LW-1:0] == '0)) // R10
        else $error("unaligned beat address");
    AST_LANES_LIVE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_be != '0)) // R10
        else $error("beat with no lanes");
endmodule

// File: rtl/stk_pushpop_unit.sv
module stk_pushpop_unit
    import stk_pkg::*;
#(
    parameter int NREGS  = 16,
    parameter int SP_IDX = 4,
    parameter int LANES  = 4,
    parameter int IDXW   = $clog2(NREGS),
    parameter int BUSW   = LANES * 8
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      mode,
    input  logic            opsz_ovr,
    input  logic            is_pop,
    input  logic [IDXW-1:0] reg_idx,
    output logic            done,
    output logic [1:0]      instr_len,
    input  logic            rf_wr_en,
    input  logic [IDXW-1:0] rf_wr_idx,
    input  logic [XLEN-1:0] rf_wr_data,
    input  logic [IDXW-1:0] rf_rd_idx,
    output logic [XLEN-1:0] rf_rd_data,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [LANES-1:0] mem_be,
    output logic [BUSW-1:0] mem_wdata,
    input  logic [BUSW-1:0] mem_rdata,
    input  logic            mem_ready
);
    stk_state_e      state_q;
    op_ctx_t         ctx_q;
    logic [IDXW-1:0] tgt_q;
    logic [XLEN-1:0] spn_q;
    logic            done_q;

    logic [3:0]      sz_n;
    logic [1:0]      sz_len;
    logic            sz_narrow;
    logic [XLEN-1:0] sp_cur, src_val, sp_push, stk_base, seq_addr, seq_acc;
    logic            seq_go, seq_fin;
    logic            rf_we;
    logic [IDXW-1:0] rf_idx, src_idx;
    logic [XLEN-1:0] rf_data;

    stk_opsize u_opsize (
        .mode   (code_mode_e'(mode)),
        .ovr    (opsz_ovr),
        .nbytes (sz_n),
        .ilen   (sz_len),
        .narrow (sz_narrow)
    );

    assign src_idx = (state_q == ST_IDLE) ? reg_idx : tgt_q;

    stk_regfile #(.NREGS(NREGS), .SP_IDX(SP_IDX), .IDXW(IDXW)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .int_we   (rf_we),
        .int_idx  (rf_idx),
        .int_data (rf_data),
        .ext_we   (rf_wr_en),
        .ext_idx  (rf_wr_idx),
        .ext_data (rf_wr_data),
        .src_idx  (src_idx),
        .src_data (src_val),
        .obs_idx  (rf_rd_idx),
        .obs_data (rf_rd_data),
        .sp_data  (sp_cur)
    );

    // A push addresses the decremented SP, a pop the current one.
    assign sp_push  = sp_step(sp_cur, sz_n, sz_narrow, 1'b1);
    assign stk_base = is_pop ? sp_cur : sp_push;
    assign seq_addr = sz_narrow ? {{(XLEN-16){1'b0}}, stk_base[15:0]} : stk_base;
    assign seq_go   = (state_q == ST_IDLE) && start;

    stk_mem_seq #(.LANES(LANES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (seq_go),
        .go_we     (!is_pop),
        .go_addr   (seq_addr),
        .go_n      (sz_n),
        .go_data   (src_val),
        .fin       (seq_fin),
        .rd_acc    (seq_acc),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready)
    );

    // SP is always written first; a pop then merges into the target,
    // which reads back the incremented SP when the target is SP.
    always_comb begin
        rf_we   = 1'b0;
        rf_idx  = IDXW'(SP_IDX);
        rf_data = spn_q;
        case (state_q)
            ST_SPWB:  rf_we = 1'b1;
            ST_REGWB: begin
                rf_we   = 1'b1;
                rf_idx  = tgt_q;
                rf_data = pop_merge(src_val, seq_acc, ctx_q.nbytes);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            tgt_q   <= '0;
            spn_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    ctx_q.is_pop <= is_pop;
                    ctx_q.narrow <= sz_narrow;
                    ctx_q.nbytes <= sz_n;
                    ctx_q.ilen   <= sz_len;
                    tgt_q        <= reg_idx;
                    spn_q        <= sp_step(sp_cur, sz_n, sz_narrow, !is_pop);
                    state_q      <= ST_MEM;
                end
                ST_MEM:  if (seq_fin) state_q <= ST_SPWB;
                ST_SPWB: begin
                    state_q <= ctx_q.is_pop ? ST_REGWB : ST_IDLE;
                    done_q  <= !ctx_q.is_pop;
                end
                ST_REGWB: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            endcase
        end
    end

    assign done      = done_q;
    assign instr_len = ctx_q.ilen;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) // R11
        else $error("done longer than one cycle");
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (instr_len == 2'd1 || instr_len == 2'd2)) // R2
        else $error("bad instruction length");
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !mem_req) // R12
        else $error("memory request while idle");
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start) |=> $stable(tgt_q)) // R12
        else $error("start accepted while busy");
    AST_SP_BEFORE_REG: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REGWB) |-> ($past(state_q) == ST_SPWB)) // R7
        else $error("register write-back not preceded by SP write");
endmodule

// File: tb/stk_pushpop_unit_bench.sv
`timescale 1ns/1ps
module stk_pushpop_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        opsz_ovr = 1'b0;
    logic        is_pop = 1'b0;
    logic [3:0]  reg_idx = 4'd0;
    logic        done;
    logic [1:0]  instr_len;
    logic        rf_wr_en = 1'b0;
    logic [3:0]  rf_wr_idx = 4'd0;
    logic [63:0] rf_wr_data = 64'd0;
    logic [3:0]  rf_rd_idx = 4'd0;
    logic [63:0] rf_rd_data;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_ready = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    stk_pushpop_unit u_stk_pushpop_unit (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .opsz_ovr(opsz_ovr),
        .is_pop(is_pop), .reg_idx(reg_idx), .done(done), .instr_len(instr_len),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    typedef struct {
        string       tag;
        bit          pop;
        int          idx;
        int          n;
        logic [1:0]  len;
        logic [63:0] addr;
        logic [63:0] val;
        logic [63:0] exp_sp;
        logic [63:0] exp_tgt;
        logic [7:0]  below;
        logic [7:0]  above;
        int          c0;
        int          w0;
    } item_t;

    item_t       q[$];
    int          pending = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          waits_total = 0;
    int          beat_seq = 0;
    int          wait_left = -1;
    bit          wait_mode = 1'b0;
    bit          prev_done = 1'b0;
    logic [63:0] model_rf [16];
    logic [7:0]  mem [logic [63:0]];

    function automatic logic [7:0] mem_rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : (a[7:0] ^ 8'hA5);
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Memory model: programmable stall, commits writes when ready is offered.
    always @(negedge clk) begin
        bit was;
        was = mem_ready;
        mem_ready = 1'b0;
        if (was) wait_left = -1;
        if (!rst && mem_req) begin
            if (wait_left < 0) wait_left = wait_mode ? (beat_seq % 3) : 0;
            if (wait_left > 0) begin
                wait_left--;
                waits_total++;
            end else begin
                mem_ready = 1'b1;
                beat_seq++;
                for (int j = 0; j < 4; j++) begin
                    if (mem_be[j]) begin
                        if (mem_we) mem[mem_addr + 64'(j)] = mem_wdata[j*8 +: 8];
                        else        mem_rdata[j*8 +: 8] = mem_rd(mem_addr + 64'(j));
                    end
                end
            end
        end
    end

    // Monitor / scoreboard.
    always @(negedge clk) begin
        item_t it;
        bit    pd;
        pd = prev_done;
        prev_done = done;
        if (!rst && done) begin
            if (pd) chk("R11 done wider than one cycle", 64'd1, 64'd0);
            if (q.size() == 0) begin
                chk("R12 done with nothing outstanding", 64'd1, 64'd0);
            end else begin
                int beats;
                it = q.pop_front();
                beats = (int'(it.addr[1:0]) + it.n - 1) / 4 + 1;
                chk({"R11 latency ", it.tag}, 64'(cyc - it.c0),
                    64'((it.pop ? 3 : 2) + beats + (waits_total - it.w0)));
                chk({"R2 length ", it.tag}, 64'(instr_len), 64'(it.len));
                rf_rd_idx = 4'd4;
                #0.5;
                chk({"SP ", it.tag}, rf_rd_data, it.exp_sp);
                rf_rd_idx = 4'(it.idx);
                #0.5;
                chk({"target ", it.tag}, rf_rd_data, it.exp_tgt);
                if (!it.pop) begin
                    logic [63:0] got;
                    got = '0;
                    for (int k = 0; k < it.n; k++) got[8*k +: 8] = mem_rd(it.addr + 64'(k));
                    chk({"R3 stored bytes ", it.tag}, got, it.val);
                    chk({"R3 byte below ", it.tag}, 64'(mem_rd(it.addr - 64'd1)), 64'(it.below));
                    chk({"R3 byte above ", it.tag}, 64'(mem_rd(it.addr + 64'(it.n))), 64'(it.above));
                end
                pending--;
            end
        end
    end

    task automatic set_reg(input int idx, input logic [63:0] v);
        @(negedge clk);
        rf_wr_en = 1'b1; rf_wr_idx = 4'(idx); rf_wr_data = v;
        @(negedge clk);
        rf_wr_en = 1'b0;
        model_rf[idx] = v;
    endtask

    // Driver: builds the expected item from the requirements, then starts.
    task automatic do_op(input logic [1:0] m, input bit ovr, input bit pop, input int idx,
                         input bit waits, input bit poke, input string tag);
        item_t       it;
        int          n;
        bit          narrow;
        logic [63:0] sp, nsp, v, cur;
        n = (m == 2'd0) ? (ovr ? 4 : 2) : (m == 2'd1) ? (ovr ? 2 : 4) : (ovr ? 2 : 8);
        narrow = (m == 2'd0);
        sp = model_rf[4];
        it.tag = tag; it.pop = pop; it.idx = idx; it.n = n; it.len = ovr ? 2'd2 : 2'd1;
        if (!pop) begin
            nsp = narrow ? {sp[63:16], sp[15:0] - 16'(n)} : sp - 64'(n);
            it.addr = narrow ? {48'd0, nsp[15:0]} : nsp;
            v = '0;
            for (int k = 0; k < n; k++) v[8*k +: 8] = model_rf[idx][8*k +: 8];
            it.val = v;
            it.below = mem_rd(it.addr - 64'd1);
            it.above = mem_rd(it.addr + 64'(n));
            model_rf[4] = nsp;
        end else begin
            it.addr = narrow ? {48'd0, sp[15:0]} : sp;
            v = '0;
            for (int k = 0; k < n; k++) v[8*k +: 8] = mem_rd(it.addr + 64'(k));
            it.val = v;
            nsp = narrow ? {sp[63:16], sp[15:0] + 16'(n)} : sp + 64'(n);
            model_rf[4] = nsp;
            cur = model_rf[idx];
            model_rf[idx] = (n == 2) ? {cur[63:16], v[15:0]} :
                            (n == 4) ? {32'd0, v[31:0]} : v;
        end
        it.exp_sp = model_rf[4];
        it.exp_tgt = model_rf[idx];
        @(negedge clk);
        mode = m; opsz_ovr = ovr; is_pop = pop; reg_idx = 4'(idx); wait_mode = waits;
        it.c0 = cyc; it.w0 = waits_total;
        q.push_back(it);
        pending++;
        start = 1'b1;
        @(negedge clk);
        if (poke) begin
            reg_idx = 4'(idx ^ 1); is_pop = !pop; opsz_ovr = !ovr;
            @(negedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        wait (pending == 0);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model_rf[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R13 done after reset", 64'(done), 64'd0);
        chk("R13 mem_req after reset", 64'(mem_req), 64'd0);
        rf_rd_idx = 4'd4;
        #0.5;
        chk("R13 SP after reset", rf_rd_data, 64'd0);

        // 64-bit mode
        set_reg(4, 64'h0000_7000_0000_1000);
        set_reg(3, 64'h1122_3344_5566_7788);
        set_reg(1, 64'hCAFE_F00D_DEAD_BEEF);
        do_op(2'd2, 1'b0, 1'b0, 3, 1'b0, 1'b0, "R1 R3 push 8B 64-bit");
        do_op(2'd2, 1'b1, 1'b0, 3, 1'b0, 1'b0, "R1 R3 push 2B 64-bit override");
        do_op(2'd2, 1'b0, 1'b0, 4, 1'b1, 1'b0, "R4 push SP 64-bit");
        do_op(2'd2, 1'b0, 1'b1, 1, 1'b0, 1'b0, "R6 pop 8B 64-bit");
        do_op(2'd2, 1'b1, 1'b1, 3, 1'b1, 1'b0, "R5 pop 2B keeps upper bits");

        // 32-bit mode, stack near a 64 KB boundary
        set_reg(2, 64'hFFFF_FFFF_1234_5678);
        set_reg(4, 64'h0000_0000_0003_FFFC);
        do_op(2'd1, 1'b0, 1'b1, 2, 1'b0, 1'b0, "R6 pop 4B clears upper");
        set_reg(4, 64'h0000_0000_0003_FFFF);
        do_op(2'd1, 1'b1, 1'b1, 4, 1'b0, 1'b0, "R7 R8 pop 2B into SP across 64K");
        set_reg(4, 64'h0000_0000_0004_0001);
        do_op(2'd1, 1'b0, 1'b0, 2, 1'b1, 1'b0, "R8 R10 push 4B across 64K with stalls");
        do_op(2'd1, 1'b0, 1'b1, 4, 1'b1, 1'b0, "R7 pop 4B into SP");

        // 16-bit mode
        set_reg(4, 64'h0000_0000_3456_0010);
        do_op(2'd0, 1'b0, 1'b0, 3, 1'b0, 1'b0, "R9 push 2B 16-bit");
        set_reg(4, 64'h0000_0000_3456_FFFE);
        do_op(2'd0, 1'b0, 1'b1, 4, 1'b0, 1'b0, "R7 R9 pop 2B into SP wraps low 16");
        set_reg(4, 64'h0000_0000_7777_0000);
        do_op(2'd0, 1'b0, 1'b0, 1, 1'b1, 1'b0, "R9 push wraps below zero");
        set_reg(6, 64'hABCD_EF01_2345_6789);
        do_op(2'd0, 1'b1, 1'b1, 6, 1'b0, 1'b0, "R1 R2 R6 pop 4B 16-bit override");

        // start held while busy with altered inputs
        do_op(2'd2, 1'b0, 1'b1, 5, 1'b1, 1'b1, "R12 start while busy");
        repeat (10) @(negedge clk);
        chk("R12 no extra done", 64'(q.size()), 64'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule